// File: doc/BRIEF.md
# Monochrome Glyph Expansion Engine

This block turns one-bit-per-pixel bitmap rows into 32-bit colour pixel writes. Software programs a packed destination coordinate, a glyph width of up to 32 pixels, a packed per-row step and a foreground/background colour pair. Each word then written to the row port expands into one pixel write request per visible bit: set bits take the foreground colour and clear bits take the background colour, so the background is always drawn. The leftmost pixel comes from the most significant bit.

After every row the destination coordinate moves by the programmed step, so a step of one line down lets software stream a glyph's rows back to back. Glyphs wider than 32 pixels are drawn as several 32-pixel columns, with software moving x between them. Pixel requests leave through a valid/ready write port. While a row is being expanded the configuration port holds `wr_ready` low, so no write is lost.

Top module: `glyph_expand`

## Requirements
- R1: After reset no pixel request is valid, `wr_ready` is high, and position, step, width and both colours are zero. So a row write before any setup draws nothing and leaves the position at zero.
- R2: Write code 0 loads the position, with y in `wr_data[31:16]` and x in `wr_data[15:0]`. Pixel k of a row (k = 0 first) is requested at x = position x + k, modulo 2^16, and at y = position y.
- R3: Write code 4 supplies a row in `wr_data[31:0]`. Pixel k takes its colour from bit 31-k.
- R4: Write code 3 loads foreground from `wr_data[63:32]` and background from `wr_data[31:0]` in one write. A set bit is drawn in the foreground colour and a clear bit in the background colour.
- R5: Write code 1 loads the width from `wr_data[5:0]`. A row write produces exactly width pixel requests, and the bits below the top width bits are never drawn.
- R6: A width value above 32 is stored as 32.
- R7: Write code 2 loads the step, with y step in `wr_data[31:16]` and x step in `wr_data[15:0]`. On the clock edge that accepts a row's last pixel, each half of the position adds its step modulo 2^16.
- R8: A row write with width 0 produces no pixel request, and the position advances by the step on the edge that accepts the write.
- R9: A position write replaces any position built up by earlier advances.
- R10: `wr_ready` is low from the edge that accepts a row with nonzero width until the edge that accepts its last pixel. A write held during that time is accepted afterwards with its data intact. Write codes 5 to 7 are accepted and have no effect.
- R11: While `pix_valid` is high and `pix_ready` is low, the pixel coordinate and colour stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Configuration or row write request |
| wr_addr | input | 3 | Write code selecting the target |
| wr_data | input | 64 | Write payload |
| wr_ready | output | 1 | Write accepted on this edge when high together with wr_valid |
| pix_valid | output | 1 | Pixel write request valid |
| pix_ready | input | 1 | Pixel memory accepts the request |
| pix_x | output | 16 | Pixel x coordinate |
| pix_y | output | 16 | Pixel y coordinate |
| pix_color | output | 32 | Pixel colour |

## Verification
The hardest situation to reach is a row write that arrives while the previous row is still stalled by pixel back-pressure. The write must be held without changing the position, and the row-end advance must land on the same edge as the last pixel handshake. The stimulus issues each row write as soon as the previous one is accepted and throttles `pix_ready` in a repeating pattern, so stalls fall both in the middle of rows and on their last pixel. Width 0, widths above 32 and position wrap-around at the 16-bit boundary are driven as separate scenarios against the cycle-level model.

// File: rtl/gx_pkg.sv
`timescale 1ns/1ps
package gx_pkg;
  parameter int COORD_W = 16;

  typedef enum logic [2:0] {
    GX_SEL_POS   = 3'd0,
    GX_SEL_WIDTH = 3'd1,
    GX_SEL_STEP  = 3'd2,
    GX_SEL_COLOR = 3'd3,
    GX_SEL_ROW   = 3'd4
  } gx_sel_e;

  typedef struct packed {
    logic [COORD_W-1:0] y;
    logic [COORD_W-1:0] x;
  } gx_xy_t;
endpackage

// File: rtl/gx_cfg_regs.sv
`timescale 1ns/1ps
module gx_cfg_regs
  import gx_pkg::*;
#(
  parameter int COLOR_W = 32,
  parameter int ROW_W   = 32,
  parameter int CNT_W   = $clog2(ROW_W + 1),
  parameter int DATA_W  = 2 * COLOR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  gx_sel_e            wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               advance,
  input  logic               busy,
  output gx_xy_t             pos,
  output logic [CNT_W-1:0]   width,
  output logic [COLOR_W-1:0] fg,
  output logic [COLOR_W-1:0] bg
);
  localparam int XY_W = 2 * COORD_W;
  localparam logic [CNT_W-1:0] WIDTH_MAX = CNT_W'(ROW_W);

  gx_xy_t             pos_q, pos_d, step_q, step_d;
  logic [CNT_W-1:0]   width_q, width_d, width_field;
  logic [COLOR_W-1:0] fg_q, fg_d, bg_q, bg_d;
  logic               pos_en, step_en, width_en, color_en;

  assign width_field = wr_data[CNT_W-1:0];

  // clock enables
  always_comb begin
    pos_en   = (wr_fire && (wr_sel == GX_SEL_POS)) || advance;
    step_en  = wr_fire && (wr_sel == GX_SEL_STEP);
    width_en = wr_fire && (wr_sel == GX_SEL_WIDTH);
    color_en = wr_fire && (wr_sel == GX_SEL_COLOR);
  end

  // next-state values
  always_comb begin
    if (advance) begin
      pos_d.x = pos_q.x + step_q.x;
      pos_d.y = pos_q.y + step_q.y;
    end else begin
      pos_d = gx_xy_t'(wr_data[XY_W-1:0]);
    end
    step_d  = gx_xy_t'(wr_data[XY_W-1:0]);
    width_d = (width_field > WIDTH_MAX) ? WIDTH_MAX : width_field;
    fg_d    = wr_data[2*COLOR_W-1:COLOR_W];
    bg_d    = wr_data[COLOR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      step_q  <= '0;
      width_q <= '0;
      fg_q    <= '0;
      bg_q    <= '0;
    end else begin
      if (pos_en)   pos_q   <= pos_d;
      if (step_en)  step_q  <= step_d;
      if (width_en) width_q <= width_d;
      if (color_en) begin
        fg_q <= fg_d;
        bg_q <= bg_d;
      end
    end
  end

  assign pos   = pos_q;
  assign width = width_q;
  assign fg    = fg_q;
  assign bg    = bg_q;

  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (pos_q.x == $past(pos_q.x + step_q.x)) && (pos_q.y == $past(pos_q.y + step_q.y))); // R7
  AST_POS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance) |=> $stable(pos_q)); // R10
  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    width_en |=> (width_q <= WIDTH_MAX)); // R6
endmodule

// File: rtl/gx_row_engine.sv
`timescale 1ns/1ps
module gx_row_engine
  import gx_pkg::*;
#(
  parameter int COLOR_W = 32,
  parameter int ROW_W   = 32,
  parameter int CNT_W   = $clog2(ROW_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ROW_W-1:0]   row_bits,
  input  logic [CNT_W-1:0]   width,
  input  gx_xy_t             base,
  input  logic [COLOR_W-1:0] fg,
  input  logic [COLOR_W-1:0] bg,
  input  logic               pix_ready,
  output logic               busy,
  output logic               advance,
  output logic               pix_valid,
  output logic [COORD_W-1:0] pix_x,
  output logic [COORD_W-1:0] pix_y,
  output logic [COLOR_W-1:0] pix_color
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             busy_q, busy_d;
  logic [ROW_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0] idx_q, idx_d, rem_q, rem_d;
  logic             fire, last, start, skip, state_en;

  always_comb begin
    fire     = busy_q && pix_ready;
    last     = (rem_q == ONE);
    start    = load && (width != '0);
    skip     = load && (width == '0);
    state_en = start || fire;
    advance  = (fire && last) || skip;
  end

  always_comb begin
    busy_d  = busy_q;
    shift_d = shift_q;
    idx_d   = idx_q;
    rem_d   = rem_q;
    if (start) begin
      busy_d  = 1'b1;
      shift_d = row_bits;
      idx_d   = '0;
      rem_d   = width;
    end else if (fire) begin
      shift_d = {shift_q[ROW_W-2:0], 1'b0};
      idx_d   = idx_q + ONE;
      rem_d   = rem_q - ONE;
      busy_d  = !last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      shift_q <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
    end else if (state_en) begin
      busy_q  <= busy_d;
      shift_q <= shift_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
    end
  end

  assign busy      = busy_q;
  assign pix_valid = busy_q;
  assign pix_x     = base.x + COORD_W'(idx_q);
  assign pix_y     = base.y;
  assign pix_color = shift_q[ROW_W-1] ? fg : bg;

  AST_PIXEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> pix_valid && $stable(pix_x) && $stable(pix_y) && $stable(pix_color)); // R11
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> pix_valid && (pix_x == $past(pix_x) + COORD_W'(1)) && $stable(pix_y)); // R2
  AST_COLOR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ((pix_color == fg) || (pix_color == bg))); // R4
  AST_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> !pix_valid); // R8
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q); // R10
endmodule

// File: rtl/glyph_expand.sv
`timescale 1ns/1ps
module glyph_expand
  import gx_pkg::*;
#(
  parameter int COLOR_W = 32,
  parameter int ROW_W   = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [2:0]             wr_addr,
  input  logic [2*COLOR_W-1:0]   wr_data,
  output logic                   wr_ready,
  output logic                   pix_valid,
  input  logic                   pix_ready,
  output logic [COORD_W-1:0]     pix_x,
  output logic [COORD_W-1:0]     pix_y,
  output logic [COLOR_W-1:0]     pix_color
);
  localparam int CNT_W  = $clog2(ROW_W + 1);
  localparam int DATA_W = 2 * COLOR_W;

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic               busy, advance, wr_fire, row_load;
  gx_sel_e            wr_sel;
  gx_xy_t             pos;
  logic [CNT_W-1:0]   width;
  logic [COLOR_W-1:0] fg, bg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    wr_sel   = gx_sel_e'(wr_addr);
    wr_ready = !busy;
    wr_fire  = wr_valid && !busy;
    row_load = wr_fire && (wr_sel == GX_SEL_ROW);
  end

  gx_cfg_regs #(
    .COLOR_W(COLOR_W), .ROW_W(ROW_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_fire(wr_fire), .wr_sel(wr_sel), .wr_data(wr_data),
    .advance(advance), .busy(busy),
    .pos(pos), .width(width), .fg(fg), .bg(bg)
  );

  gx_row_engine #(
    .COLOR_W(COLOR_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_engine (
    .clk(clk), .rst_n(rst_sync_n),
    .load(row_load), .row_bits(wr_data[ROW_W-1:0]), .width(width),
    .base(pos), .fg(fg), .bg(bg), .pix_ready(pix_ready),
    .busy(busy), .advance(advance),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color)
  );

  AST_STALL_WHILE_DRAWING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pix_valid |-> !wr_ready); // R10
endmodule

// File: tb/glyph_expand_bench.sv
`timescale 1ns/1ps
module glyph_expand_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid, pix_ready;
  logic [2:0]  wr_addr;
  logic [63:0] wr_data;
  logic        wr_ready, pix_valid;
  logic [15:0] pix_x, pix_y;
  logic [31:0] pix_color;

  glyph_expand u_glyph_expand (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ready(wr_ready), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color)
  );

  always #5 clk = ~clk;

  int    vectors = 0, miscompares = 0, cyc = 0;
  bit    finished = 0, bp = 0, last_acc = 0, held = 0;
  string scen = "R1";

  // reference model state
  logic [15:0] m_px = 0, m_py = 0, m_sx = 0, m_sy = 0;
  logic [31:0] m_fg = 0, m_bg = 0, m_shift = 0;
  int          m_width = 0, m_idx = 0, m_w = 0;
  bit          m_busy = 0;
  logic [15:0] h_x, h_y;
  logic [31:0] h_c;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL [%s] %s: actual %0h expected %0h", scen, what, act, exp);
    end
  endtask

  task automatic model_advance();
    m_px = m_px + m_sx;
    m_py = m_py + m_sy;
  endtask

  task automatic cycle();
    bit acc, fire;
    logic [15:0] ex;
    cyc++;
    pix_ready = bp ? ((cyc % 3) != 1) : 1'b1;
    #1;
    chk("R10 wr_ready", wr_ready, !m_busy);
    chk("R5 pix_valid", pix_valid, m_busy);
    if (m_busy) begin
      ex = m_px + 16'(m_idx);
      chk("R2 pix_x", pix_x, ex);
      chk("R2 pix_y", pix_y, m_py);
      chk("R3 R4 pix_color", pix_color, m_shift[31] ? m_fg : m_bg);
    end
    if (held) begin
      chk("R11 held x", pix_x, h_x);
      chk("R11 held y", pix_y, h_y);
      chk("R11 held colour", pix_color, h_c);
    end
    held = pix_valid && !pix_ready;
    h_x = pix_x; h_y = pix_y; h_c = pix_color;
    acc  = wr_valid && !m_busy;
    fire = m_busy && pix_ready;
    if (fire) begin
      m_shift = m_shift << 1;
      m_idx++;
      if (m_idx == m_w) begin
        m_busy = 0;
        model_advance();
      end
    end
    if (acc) begin
      case (wr_addr)
        3'd0: begin m_py = wr_data[31:16]; m_px = wr_data[15:0]; end
        3'd1: begin m_width = int'(wr_data[5:0]); if (m_width > 32) m_width = 32; end
        3'd2: begin m_sy = wr_data[31:16]; m_sx = wr_data[15:0]; end
        3'd3: begin m_fg = wr_data[63:32]; m_bg = wr_data[31:0]; end
        3'd4: begin
          if (m_width == 0) model_advance();
          else begin
            m_busy = 1; m_shift = wr_data[31:0]; m_idx = 0; m_w = m_width;
          end
        end
        default: ;
      endcase
    end
    last_acc = acc;
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [63:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    do cycle(); while (!last_acc);
    wr_valid = 1'b0; wr_data = 64'hDEAD_BEEF_0BAD_F00D;
  endtask

  task automatic drain();
    while (m_busy) cycle();
    cycle();
  endtask

  initial begin
    wr_valid = 0; wr_addr = 0; wr_data = 0; pix_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then a row write with the reset width of zero
    repeat (4) cycle();
    write_reg(3'd4, 64'hFFFF_FFFF);
    repeat (2) cycle();

    scen = "R3 R4 R5";
    write_reg(3'd3, {32'hA5A5_0001, 32'h0000_5A5A});
    write_reg(3'd0, {32'd0, 16'd5, 16'd10});
    write_reg(3'd2, 64'h0001_0000);
    write_reg(3'd1, 64'd8);
    write_reg(3'd4, 64'hB400_00FF);
    write_reg(3'd4, 64'h8000_0001);
    write_reg(3'd4, 64'h7F00_0000);
    drain();
    write_reg(3'd1, 64'd1);
    write_reg(3'd4, 64'h8000_0000);
    write_reg(3'd4, 64'h7FFF_FFFF);
    write_reg(3'd1, 64'd31);
    write_reg(3'd4, 64'hAAAA_AAAB);
    drain();

    scen = "R10 R11";
    bp = 1;
    write_reg(3'd1, 64'd32);
    write_reg(3'd4, 64'hF0F0_0F0F);
    write_reg(3'd0, {32'd0, 16'd40, 16'd100});
    write_reg(3'd4, 64'h1234_5678);
    write_reg(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    write_reg(3'd4, 64'hC3C3_3C3C);
    drain();
    bp = 0;

    scen = "R6";
    write_reg(3'd1, 64'd40);
    write_reg(3'd4, 64'h8000_0001);
    write_reg(3'd1, 64'd63);
    write_reg(3'd4, 64'h0000_0001);
    drain();

    scen = "R7";
    write_reg(3'd0, {32'd0, 16'hFFFF, 16'hFFFE});
    write_reg(3'd2, {32'd0, 16'd2, 16'd3});
    write_reg(3'd1, 64'd5);
    write_reg(3'd4, 64'hA800_0000);
    write_reg(3'd4, 64'h5000_0000);
    drain();

    scen = "R8";
    write_reg(3'd1, 64'd0);
    write_reg(3'd4, 64'hFFFF_FFFF);
    write_reg(3'd4, 64'hFFFF_FFFF);
    write_reg(3'd1, 64'd3);
    write_reg(3'd4, 64'hE000_0000);
    drain();

    scen = "R9";
    write_reg(3'd0, {32'd0, 16'd7, 16'd9});
    write_reg(3'd4, 64'h6000_0000);
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      $display("FAIL [%s] watchdog: actual hung expected completion", scen);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule